// File: doc/BRIEF.md
# Byte-Wide Serial Shift Interface with Busy Flag

This block moves one byte in and one byte out at the same time over a three-wire synchronous serial link: serial data out, serial data in and a shift clock. It works as clock master, dividing the system clock to make the shift clock, or as slave, following a shift clock that arrives on an input pin. The shift clock rests high between transfers.

Software loads the shift byte, sets the busy flag, and the block shifts eight bits, most significant bit first. Each received bit enters at the least significant end. Hardware drops the busy flag after the eighth bit and can raise an interrupt pulse. Software can also drop the busy flag part way through. Shifting then stops and the bits already exchanged stay in the shift byte.

There are two clocking modes. In normal mode, data out changes on the falling shift-clock edge and data in is sampled on the rising edge. In alternate mode, data out changes on the rising edge and data in is sampled on the falling edge. An enable routes the data-out and clock functions onto the pins through output enables.

Top module: `bfs_shifter`

## Requirements
- R1: After reset, busy and irq are 0, sck_out and sdo are 1, and shift_byte is 0.
- R2: A one-cycle busy_set while busy is 0 makes busy 1 from the next cycle. A busy_set while busy is 1 has no effect, and the transfer still lasts the same number of cycles.
- R3: In master mode the shift clock period is 2, 4 or 8 system clocks for cfg_div 0, 1 or 2, and cfg_div 3 gives 8. Whenever busy is 0, sck_out is 1.
- R4: Bits leave on sdo most significant bit first. Each bit sampled from sdi enters shift_byte at bit 0 as the byte moves one place toward bit 7. With sdo looped back to sdi, a full transfer returns the loaded byte unchanged.
- R5: Normal mode (cfg_alt = 0): sdo changes only on a falling shift-clock edge, and sdi is sampled on the rising edge.
- R6: Alternate mode (cfg_alt = 1): sdo shows the most significant bit as soon as busy is set and changes on rising edges. sdi is sampled on the falling edge.
- R7: busy returns to 0 at the eighth rising shift-clock edge. In master mode busy stays high for exactly 16 times the half period, in system clocks.
- R8: A busy_clr while busy is 1 drops busy and returns sck_out high at the next clock edge. The bits already shifted remain in shift_byte, and no interrupt is raised.
- R9: When irq_en is 1, irq is a one-cycle pulse in the cycle in which busy has just dropped after eight bits. When irq_en is 0, irq stays 0.
- R10: In slave mode, sck_in passes through a two-stage synchronizer before its edges are detected. Edges seen while busy is 0 leave shift_byte unchanged.
- R11: sdo_oe equals cfg_pin_en, and sck_oe is 1 only when cfg_pin_en and cfg_master are both 1.
- R12: A data_wr while busy is 1 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous reset, active low |
| data_wr | input | 1 | load wr_byte into the shift byte (ignored while busy) |
| wr_byte | input | DATA_W | value to load |
| busy_set | input | 1 | software sets the busy flag |
| busy_clr | input | 1 | software clears the busy flag |
| cfg_master | input | 1 | 1 = generate the shift clock, 0 = follow sck_in |
| cfg_alt | input | 1 | 1 = alternate clocking mode |
| cfg_pin_en | input | 1 | route the data-out and clock functions to the pins |
| cfg_div | input | DIV_W | master clock divide select (2, 4, 8, 8) |
| irq_en | input | 1 | enable the completion interrupt |
| shift_byte | output | DATA_W | current shift register contents |
| busy | output | 1 | busy flag |
| irq | output | 1 | completion interrupt pulse |
| sdo | output | 1 | serial data out |
| sdo_oe | output | 1 | output enable for sdo |
| sck_out | output | 1 | master shift clock, idle high |
| sck_oe | output | 1 | output enable for sck_out |
| sck_in | input | 1 | external shift clock in slave mode |
| sdi | input | 1 | serial data in |

## Verification
In master mode, bytes are sent with sdo looped back to sdi, in both clocking modes and at every divide setting. A correct round trip together with the bits captured on each shift-clock edge separates bit order from edge choice, and the measured clock period and busy length separate the divider settings. A constant sdi with a software clear partway through shows that a partial shift stops on an exact bit count and is kept. In slave mode the bench drives an externally timed clock with data that differs from the sent byte, and then sends extra pulses after completion, which shows that the synchronized edges are followed only while busy. A behavioural model is compared against every output on every cycle throughout.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

   // one-cycle markers of shift-clock transitions, in the system clock domain
   typedef struct packed {
      logic rise;
      logic fall;
   } sck_evt_t;

   // clamp a divide select to the largest supported half-period exponent
   function automatic int unsigned half_exp(input int unsigned sel, input int unsigned max_exp);
      return (sel > max_exp) ? max_exp : sel;
   endfunction

endpackage

// File: rtl/bfs_mclk.sv
module bfs_mclk #(
   parameter int MAX_HALF_EXP = 2,
   parameter int DIV_W        = 2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 run,
   input  logic [DIV_W-1:0]     div_sel,
   output logic                 sck,
   output bfs_pkg::sck_evt_t    evt
);
   localparam int CNT_W = (MAX_HALF_EXP < 1) ? 1 : MAX_HALF_EXP;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic             tick;

   always_comb begin
      int unsigned e;
      e     = bfs_pkg::half_exp(int'(div_sel), MAX_HALF_EXP);
      limit = CNT_W'((32'd1 << e) - 32'd1);
   end

   assign tick     = run && (cnt == limit);
   assign evt.fall = tick &  sck;
   assign evt.rise = tick & ~sck;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         sck <= 1'b1;
      end else if (!run) begin
         cnt <= '0;
         sck <= 1'b1;
      end else if (tick) begin
         cnt <= '0;
         sck <= ~sck;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/bfs_ssync.sv
module bfs_ssync #(
   parameter int STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sck_pin,
   output bfs_pkg::sck_evt_t evt
);
   // stages 0..STAGES-1 synchronize, stage STAGES holds the previous value
   logic [STAGES:0] pipe;

   generate
      for (genvar i = 0; i <= STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[0] <= 1'b1;
               else        pipe[0] <= sck_pin;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) pipe[i] <= 1'b1;
               else        pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   assign evt.rise =  pipe[STAGES-1] & ~pipe[STAGES];
   assign evt.fall = ~pipe[STAGES-1] &  pipe[STAGES];
endmodule

// File: rtl/bfs_core.sv
module bfs_core #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              busy_set,
   input  logic              busy_clr,
   input  logic              alt_mode,
   input  logic              irq_en,
   input  bfs_pkg::sck_evt_t evt,
   input  logic              sdi,
   output logic [DATA_W-1:0] shift_byte,
   output logic              busy,
   output logic              irq,
   output logic              sdo
);
   localparam int              BC_W = (DATA_W < 2) ? 1 : $clog2(DATA_W);
   localparam logic [BC_W-1:0] LAST = BC_W'(DATA_W - 1);

   logic [DATA_W-1:0] sh;
   logic [BC_W-1:0]   bits;
   logic              busy_q, sdo_q, smp_q, irq_q;
   logic              in_bit, done;

   assign in_bit = alt_mode ? smp_q : sdi;
   assign done   = busy_q & ~busy_clr & evt.rise & (bits == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh     <= '0;
         bits   <= '0;
         busy_q <= 1'b0;
         sdo_q  <= 1'b1;
         smp_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         irq_q <= done & irq_en;
         if (busy_q) begin
            if (busy_clr) begin
               busy_q <= 1'b0;
            end else begin
               if (evt.fall) begin
                  if (alt_mode) smp_q <= sdi;
                  else          sdo_q <= sh[DATA_W-1];
               end
               if (evt.rise) begin
                  sh   <= {sh[DATA_W-2:0], in_bit};
                  bits <= bits + 1'b1;
                  if (alt_mode)       sdo_q  <= sh[DATA_W-2];
                  if (bits == LAST)   busy_q <= 1'b0;
               end
            end
         end else begin
            if (data_wr) sh <= wr_byte;
            if (busy_set) begin
               busy_q <= 1'b1;
               bits   <= '0;
               sdo_q  <= data_wr ? wr_byte[DATA_W-1] : sh[DATA_W-1];
            end
         end
      end
   end

   assign shift_byte = sh;
   assign busy       = busy_q;
   assign irq        = irq_q;
   assign sdo        = sdo_q;
endmodule

// File: rtl/bfs_shifter.sv
module bfs_shifter #(
   parameter int DATA_W       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int MAX_HALF_EXP = 2,
   parameter int DIV_W        = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              data_wr,
   input  logic [DATA_W-1:0] wr_byte,
   input  logic              busy_set,
   input  logic              busy_clr,
   input  logic              cfg_master,
   input  logic              cfg_alt,
   input  logic              cfg_pin_en,
   input  logic [DIV_W-1:0]  cfg_div,
   input  logic              irq_en,
   output logic [DATA_W-1:0] shift_byte,
   output logic              busy,
   output logic              irq,
   output logic              sdo,
   output logic              sdo_oe,
   output logic              sck_out,
   output logic              sck_oe,
   input  logic              sck_in,
   input  logic              sdi
);
   generate
      if (DATA_W < 2) begin : g_bad_width
         $error("bfs_shifter: DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("bfs_shifter: SYNC_STAGES must be at least 2");
      end
      if (MAX_HALF_EXP < 0 || MAX_HALF_EXP > 8) begin : g_bad_div
         $error("bfs_shifter: MAX_HALF_EXP out of range");
      end
   endgenerate

   bfs_pkg::sck_evt_t m_evt, s_evt, evt;
   logic              m_sck, run;

   assign run = busy & ~busy_clr & cfg_master;

   bfs_mclk #(.MAX_HALF_EXP(MAX_HALF_EXP), .DIV_W(DIV_W)) u_mclk (
      .clk(clk), .rst_n(rst_n), .run(run), .div_sel(cfg_div), .sck(m_sck), .evt(m_evt)
   );

   bfs_ssync #(.STAGES(SYNC_STAGES)) u_ssync (
      .clk(clk), .rst_n(rst_n), .sck_pin(sck_in), .evt(s_evt)
   );

   assign evt = cfg_master ? m_evt : s_evt;

   bfs_core #(.DATA_W(DATA_W)) u_core (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wr_byte(wr_byte),
      .busy_set(busy_set), .busy_clr(busy_clr), .alt_mode(cfg_alt), .irq_en(irq_en),
      .evt(evt), .sdi(sdi), .shift_byte(shift_byte), .busy(busy), .irq(irq), .sdo(sdo)
   );

   assign sck_out = cfg_master ? m_sck : 1'b1;
   assign sdo_oe  = cfg_pin_en;
   assign sck_oe  = cfg_pin_en & cfg_master;
endmodule

// File: rtl/bfs_shifter_chk.sv
module bfs_shifter_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              data_wr,
   input logic              busy_set,
   input logic              busy_clr,
   input logic              cfg_master,
   input logic              cfg_pin_en,
   input logic              irq_en,
   input logic [DATA_W-1:0] shift_byte,
   input logic              busy,
   input logic              irq,
   input logic              sdo_oe,
   input logic              sck_out,
   input logic              sck_oe
);
   p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(busy_set));

   p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> sck_out);

   p_done_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(busy_clr)) |-> (irq == $past(irq_en)));

   p_clear_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && busy_clr) |=> (!busy && sck_out && !irq));

   p_irq_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |=> !irq);

   p_irq_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> !busy);

   p_byte_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !data_wr) |=> $stable(shift_byte));

   p_pin_route_r11: assert property (@(posedge clk) disable iff (!rst_n)
      sck_oe |-> (cfg_master && sdo_oe && cfg_pin_en));
endmodule

bind bfs_shifter bfs_shifter_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_bfs_shifter.sv
module test_bfs_shifter;
   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic       rst_n, data_wr, busy_set, busy_clr, cfg_master, cfg_alt, cfg_pin_en, irq_en;
   logic [7:0] wr_byte;
   logic [1:0] cfg_div;
   logic       sck_in, sdi_drv, loop;
   logic [7:0] shift_byte;
   logic       busy, irq, sdo, sdo_oe, sck_out, sck_oe;
   logic       sdi;

   assign sdi = loop ? sdo : sdi_drv;

   bfs_shifter i_bfs_shifter (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .wr_byte(wr_byte),
      .busy_set(busy_set), .busy_clr(busy_clr), .cfg_master(cfg_master), .cfg_alt(cfg_alt),
      .cfg_pin_en(cfg_pin_en), .cfg_div(cfg_div), .irq_en(irq_en),
      .shift_byte(shift_byte), .busy(busy), .irq(irq), .sdo(sdo), .sdo_oe(sdo_oe),
      .sck_out(sck_out), .sck_oe(sck_oe), .sck_in(sck_in), .sdi(sdi)
   );

   int n_chk = 0, n_bad = 0, cyc = 0;
   bit finished = 0, cmp_on = 0;

   function automatic void check(bit ok, string req, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endfunction

   // behavioural reference: updated at every rising clock edge
   logic [7:0] m_sh;
   logic       m_busy, m_sdo, m_sck, m_irq, m_smp;
   int         m_cnt, m_bits;
   logic [2:0] m_hist;

   always @(posedge clk) begin
      int   half;
      logic r, f, was, fin, running;
      if (!rst_n) begin
         m_sh = 8'h00; m_busy = 0; m_sdo = 1; m_sck = 1; m_irq = 0; m_smp = 0;
         m_cnt = 0; m_bits = 0; m_hist = 3'b111;
      end else begin
         half = 1 << ((cfg_div > 2) ? 2 : cfg_div);
         r = 0; f = 0; fin = 0; was = m_busy;
         running = cfg_master && m_busy && !busy_clr;
         if (running) begin
            if (m_cnt == half - 1) begin
               m_cnt = 0;
               if (m_sck) f = 1; else r = 1;
               m_sck = !m_sck;
            end else m_cnt++;
         end else begin
            m_cnt = 0; m_sck = 1;
         end
         if (!cfg_master) begin
            r = m_hist[1] && !m_hist[2];
            f = !m_hist[1] && m_hist[2];
         end
         m_hist = {m_hist[1:0], sck_in};
         if (was) begin
            if (busy_clr) m_busy = 0;
            else begin
               if (f) begin
                  if (cfg_alt) m_smp = sdi; else m_sdo = m_sh[7];
               end
               if (r) begin
                  if (cfg_alt) begin
                     m_sdo = m_sh[6];
                     m_sh  = {m_sh[6:0], m_smp};
                  end else m_sh = {m_sh[6:0], sdi};
                  m_bits++;
                  if (m_bits == 8) begin m_busy = 0; fin = 1; end
               end
            end
         end else begin
            if (data_wr) m_sh = wr_byte;
            if (busy_set) begin m_busy = 1; m_bits = 0; m_sdo = m_sh[7]; end
         end
         m_irq = fin && irq_en;
      end
   end

   // per-cycle comparison and observation monitors
   int         busy_cycles, irq_cnt, last_fall, period;
   bit         have_fall, prev_sck;
   logic [7:0] cap_rise, cap_fall;

   always @(negedge clk) begin
      if (rst_n && cmp_on) begin
         check(busy == m_busy, "R7 busy vs model", busy, m_busy);
         check(shift_byte == m_sh, "R4 shift_byte vs model", shift_byte, m_sh);
         check(sdo == m_sdo, "R5 sdo vs model", sdo, m_sdo);
         check(sck_out == (cfg_master ? m_sck : 1'b1), "R3 sck_out vs model", sck_out, cfg_master ? m_sck : 1'b1);
         check(irq == m_irq, "R9 irq vs model", irq, m_irq);
         check({sdo_oe, sck_oe} == {cfg_pin_en, cfg_pin_en & cfg_master}, "R11 enables",
               {sdo_oe, sck_oe}, {cfg_pin_en, cfg_pin_en & cfg_master});
      end
      if (busy) busy_cycles++;
      if (irq) irq_cnt++;
      if (prev_sck && !sck_out) begin
         if (have_fall) period = cyc - last_fall;
         last_fall = cyc; have_fall = 1;
         cap_fall = {cap_fall[6:0], sdo};
      end
      if (!prev_sck && sck_out) cap_rise = {cap_rise[6:0], sdo};
      prev_sck = sck_out;
   end

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
         summary();
      end
   end

   task automatic wait_idle();
      for (int i = 0; i < 400 && busy; i++) @(negedge clk);
   endtask

   task automatic start_monitors();
      busy_cycles = 0; irq_cnt = 0; have_fall = 0; period = 0;
      cap_rise = 8'h00; cap_fall = 8'h00;
   endtask

   task automatic master_xfer(logic [7:0] b, logic [1:0] div, logic alt, logic ien);
      int half;
      half = 1 << ((div > 2) ? 2 : div);
      @(negedge clk);
      cfg_master = 1; cfg_alt = alt; cfg_div = div; irq_en = ien; loop = 1;
      data_wr = 1; wr_byte = b;
      @(negedge clk);
      data_wr = 0; busy_set = 1; start_monitors();
      @(negedge clk);
      busy_set = 0;
      repeat (3) @(negedge clk);
      busy_set = 1; data_wr = 1; wr_byte = ~b;   // both must be ignored (R2, R12)
      @(negedge clk);
      busy_set = 0; data_wr = 0;
      wait_idle();
      repeat (3) @(negedge clk);
      check(shift_byte == b, "R4 R12 loopback result", shift_byte, b);
      check(period == 2 * half, "R3 shift clock period", period, 2 * half);
      check(busy_cycles == 16 * half, "R7 R2 busy length", busy_cycles, 16 * half);
      check(irq_cnt == (ien ? 1 : 0), "R9 interrupt count", irq_cnt, ien ? 1 : 0);
      if (alt) check(cap_fall == b, "R6 sdo sampled at falling edges", cap_fall, b);
      else     check(cap_rise == b, "R5 sdo sampled at rising edges", cap_rise, b);
   endtask

   task automatic slave_xfer(logic [7:0] tx, logic [7:0] rx, logic alt);
      logic [7:0] got;
      got = 8'h00;
      @(negedge clk);
      cfg_master = 0; cfg_alt = alt; irq_en = 1; loop = 0; sck_in = 1;
      data_wr = 1; wr_byte = tx;
      @(negedge clk);
      data_wr = 0; busy_set = 1; start_monitors();
      @(negedge clk);
      busy_set = 0;
      for (int i = 7; i >= 0; i--) begin
         if (!alt) begin
            sck_in = 0; sdi_drv = rx[i];
            repeat (6) @(negedge clk);
            got = {got[6:0], sdo};
            sck_in = 1;
            repeat (6) @(negedge clk);
         end else begin
            sdi_drv = rx[i];
            repeat (6) @(negedge clk);
            got = {got[6:0], sdo};
            sck_in = 0;
            repeat (6) @(negedge clk);
            sck_in = 1;
         end
      end
      repeat (6) @(negedge clk);
      check(busy == 0, "R7 R10 slave busy cleared", busy, 0);
      check(shift_byte == rx, "R10 R4 slave received byte", shift_byte, rx);
      check(got == tx, alt ? "R6 slave sent byte" : "R5 slave sent byte", got, tx);
      check(irq_cnt == 1, "R9 slave interrupt", irq_cnt, 1);
   endtask

   initial begin
      rst_n = 0; data_wr = 0; busy_set = 0; busy_clr = 0; cfg_master = 1; cfg_alt = 0;
      cfg_pin_en = 0; cfg_div = 0; irq_en = 0; wr_byte = 0; sck_in = 1; sdi_drv = 0; loop = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      check(busy == 0, "R1 busy after reset", busy, 0);
      check(irq == 0, "R1 irq after reset", irq, 0);
      check(sck_out == 1, "R1 sck_out after reset", sck_out, 1);
      check(sdo == 1, "R1 sdo after reset", sdo, 1);
      check(shift_byte == 0, "R1 shift_byte after reset", shift_byte, 0);
      cmp_on = 1;

      check({sdo_oe, sck_oe} == 2'b00, "R11 pins disabled", {sdo_oe, sck_oe}, 0);
      cfg_pin_en = 1;
      @(negedge clk);
      check({sdo_oe, sck_oe} == 2'b11, "R11 master pins", {sdo_oe, sck_oe}, 3);
      cfg_master = 0;
      @(negedge clk);
      check({sdo_oe, sck_oe} == 2'b10, "R11 slave pins", {sdo_oe, sck_oe}, 2);

      master_xfer(8'hA5, 2'd0, 1'b0, 1'b1);
      master_xfer(8'h3C, 2'd1, 1'b1, 1'b0);
      master_xfer(8'h96, 2'd2, 1'b0, 1'b1);
      master_xfer(8'h61, 2'd3, 1'b1, 1'b1);

      // R8: software clear after two rising edges at divide-by-8
      @(negedge clk);
      cfg_master = 1; cfg_alt = 0; cfg_div = 2; irq_en = 1; loop = 0; sdi_drv = 1;
      data_wr = 1; wr_byte = 8'h00;
      @(negedge clk);
      data_wr = 0; busy_set = 1; start_monitors();
      @(negedge clk);
      busy_set = 0;
      repeat (17) @(negedge clk);
      busy_clr = 1;
      @(negedge clk);
      busy_clr = 0;
      check(busy == 0, "R8 busy dropped", busy, 0);
      check(sck_out == 1, "R8 clock back high", sck_out, 1);
      check(shift_byte == 8'h03, "R8 partial shift kept", shift_byte, 8'h03);
      repeat (20) @(negedge clk);
      check(shift_byte == 8'h03, "R8 partial shift still kept", shift_byte, 8'h03);
      check(irq_cnt == 0, "R8 no interrupt on early stop", irq_cnt, 0);

      slave_xfer(8'h5A, 8'hC3, 1'b0);
      irq_cnt = 0;
      for (int k = 0; k < 3; k++) begin
         sck_in = 0; sdi_drv = k[0];
         repeat (6) @(negedge clk);
         sck_in = 1;
         repeat (6) @(negedge clk);
      end
      check(shift_byte == 8'hC3, "R10 extra pulses ignored", shift_byte, 8'hC3);
      check(busy == 0 && irq_cnt == 0, "R10 idle after extra pulses", {busy, irq_cnt[0]}, 0);

      slave_xfer(8'hB4, 8'h2E, 1'b1);
      repeat (5) @(negedge clk);
      summary();
   end
endmodule